// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master that runs one read or one write cycle at a time against an external PHY over a two-wire serial management link (a clock line, MDC, and a bidirectional data line, MDIO). A host sees three registers on a simple write port. The control register holds the MDC divisor and a preamble-skip bit. The data register holds the value to write, or the value returned by a read. A write to the command register starts a cycle.

For a write, the host loads the data register, then writes a command with the write flag set. For a read, it writes a command with the read flag set. The host watches `busy` until it falls and then takes the result from `mgmt_data`. MDC comes from dividing the system clock. The block drives MDIO on MDC falling edges. During the turnaround and data phase of a read it releases the line and samples it on MDC rising edges.

Top module: `mdio_master`

## Requirements
- R1: After reset, `busy`, `mdc` and `mdio_oe` are low, `mgmt_data` is 0, `cfg_div` is 32 and `cfg_nopre` is 0.
- R2: The command register is address 2. It holds the register number in bits [4:0], the PHY number in bits [9:5], a read flag in bit 10 and a write flag in bit 11. When the block is idle, a command with exactly one flag set starts a cycle. `busy` is high from the next clock until the cycle ends.
- R3: Each cycle shifts out, MSB first, 32 ones of preamble, then start bits 01, opcode 10 (read) or 01 (write), the 5-bit PHY number, the 5-bit register number, turnaround 10 and 16 data bits. When the control register's bit 8 (preamble skip) is set at the start of a cycle, the preamble is left out.
- R4: The control register is address 0, with the divisor in bits [7:0]. MDC has a period of 2*max(floor(div/2),1) system clocks. MDC stays low while the block is idle.
- R5: Within a cycle, MDIO output changes only together with a falling edge of MDC.
- R6: In a read, `mdio_oe` is low from the first turnaround bit to the end of the frame. The 16 data bits are sampled on MDC rising edges and appear in `mgmt_data` by the time `busy` is low.
- R7: The data register is address 1, with the data in bits [15:0]. In a write, its value is sent as the data field, `mdio_oe` stays high for the whole frame, and the register keeps its value afterwards.
- R8: Register writes are ignored while `busy` is high, and the cycle in flight is left undisturbed. A command with both flags set, or with neither, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 data, 2 command |
| reg_wdata | input | 16 | Register write data |
| cfg_div | output | 8 | Current MDC divisor |
| cfg_nopre | output | 1 | Current preamble-skip setting |
| mgmt_data | output | 16 | Data register contents |
| busy | output | 1 | Cycle in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
Two events can land on the same clock edge: a host write to the data register, and the capture of read data when the last falling MDC edge ends a read. The bench forces the overlap by holding a data-register write on every clock for the whole of a read. It then requires `mgmt_data` to hold the PHY's value, not the host's. Commands, data and control writes issued in the middle of a cycle are judged the same way: the frame seen on the wire, the divisor and the data register must all be unchanged.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   typedef enum logic [1:0] {
      RA_CTRL = 2'd0,
      RA_DATA = 2'd1,
      RA_CMD  = 2'd2,
      RA_NONE = 2'd3
   } mdio_reg_e;

   localparam logic [1:0] SOF_BITS  = 2'b01;
   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] TA_WRITE  = 2'b10;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise_stb,
   output logic             fall_stb
);
   logic [DIV_W-1:0] half;
   logic [DIV_W-1:0] cnt;
   logic             wrap;

   // half period in system clocks, never below one
   always_comb begin
      if (div[DIV_W-1:1] == '0) half = DIV_W'(1);
      else                      half = {1'b0, div[DIV_W-1:1]};
      wrap     = run && (cnt == half - DIV_W'(1));
      rise_stb = wrap && !mdc;
      fall_stb = wrap && mdc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + DIV_W'(1);
      end
   end
endmodule

// File: rtl/mdio_insync.sv
module mdio_insync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else if (STAGES == 1) begin : g_one
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b1;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '1;
            else        r <= {r[STAGES-2:0], d};
         end
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_pkg::*;
#(
   parameter int PHY_AW  = 5,
   parameter int REG_AW  = 5,
   parameter int DATA_W  = 16,
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_rd,
   input  logic              start_nopre,
   input  logic [PHY_AW-1:0] phy,
   input  logic [REG_AW-1:0] regad,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rise_stb,
   input  logic              fall_stb,
   input  logic              mdio_in,
   output logic              busy,
   output logic              rd_op,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              rd_done,
   output logic [DATA_W-1:0] rd_word
);
   localparam int HDR_W   = 4 + PHY_AW + REG_AW;
   localparam int FRAME_W = HDR_W + 2 + DATA_W;
   localparam int TOT_W   = PRE_LEN + FRAME_W;
   localparam int TA_POS  = PRE_LEN + HDR_W;
   localparam int DAT_POS = TA_POS + 2;
   localparam int LAST    = TOT_W - 1;
   localparam int IDX_W   = $clog2(TOT_W + 1);

   logic [FRAME_W-1:0] frame;
   logic [TOT_W-1:0]   load_word;
   logic [TOT_W-1:0]   shreg;
   logic [IDX_W-1:0]   idx;
   logic [DATA_W-1:0]  rx;
   logic               at_last;

   always_comb begin
      frame = {SOF_BITS, (start_rd ? OPC_READ : OPC_WRITE), phy, regad,
               TA_WRITE, (start_rd ? {DATA_W{1'b0}} : wdata)};
      if (start_nopre) load_word = {frame, {PRE_LEN{1'b0}}};
      else             load_word = {{PRE_LEN{1'b1}}, frame};
   end

   assign at_last = (idx == IDX_W'(LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         rd_op <= 1'b0;
         idx   <= '0;
         shreg <= '0;
         rx    <= '0;
      end else if (start && !busy) begin
         busy  <= 1'b1;
         rd_op <= start_rd;
         idx   <= start_nopre ? IDX_W'(PRE_LEN) : '0;
         shreg <= load_word;
         rx    <= '0;
      end else if (busy) begin
         if (rise_stb && idx >= IDX_W'(DAT_POS))
            rx <= {rx[DATA_W-2:0], mdio_in};
         if (fall_stb) begin
            if (at_last) begin
               busy <= 1'b0;
            end else begin
               idx   <= idx + IDX_W'(1);
               shreg <= {shreg[TOT_W-2:0], 1'b0};
            end
         end
      end
   end

   assign mdio_o  = shreg[TOT_W-1];
   assign mdio_oe = busy && !(rd_op && idx >= IDX_W'(TA_POS));
   assign rd_done = busy && rd_op && fall_stb && at_last;
   assign rd_word = rx;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int DIV_RST     = 32,
   parameter int PHY_AW      = 5,
   parameter int REG_AW      = 5,
   parameter int DATA_W      = 16,
   parameter int PRE_LEN     = 32,
   parameter int HOST_W      = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [HOST_W-1:0] reg_wdata,
   output logic [DIV_W-1:0]  cfg_div,
   output logic              cfg_nopre,
   output logic [DATA_W-1:0] mgmt_data,
   output logic              busy,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   localparam int RD_BIT    = REG_AW + PHY_AW;
   localparam int WR_BIT    = RD_BIT + 1;
   localparam int NOPRE_BIT = DIV_W;

   generate
      if (HOST_W < WR_BIT + 1 || HOST_W < DATA_W || HOST_W < NOPRE_BIT + 1) begin : g_bad_host
         $fatal(1, "mdio_master: HOST_W too narrow for register fields");
      end
      if (DIV_RST < 2 || DIV_RST >= (1 << DIV_W)) begin : g_bad_div
         $fatal(1, "mdio_master: DIV_RST out of range");
      end
      if (PRE_LEN < 1 || DATA_W < 2) begin : g_bad_frame
         $fatal(1, "mdio_master: PRE_LEN and DATA_W too small");
      end
   endgenerate

   logic              wr_ok;
   logic              cmd_rd;
   logic              cmd_wr;
   logic              cmd_go;
   logic              rise_stb;
   logic              fall_stb;
   logic              seq_rd;
   logic              rd_done;
   logic [DATA_W-1:0] rd_word;
   logic              mdio_s;

   assign wr_ok  = reg_wr && !busy;
   assign cmd_rd = reg_wdata[RD_BIT];
   assign cmd_wr = reg_wdata[WR_BIT];
   assign cmd_go = wr_ok && (reg_addr == RA_CMD) && (cmd_rd ^ cmd_wr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_div   <= DIV_W'(DIV_RST);
         cfg_nopre <= 1'b0;
         mgmt_data <= '0;
      end else begin
         if (rd_done)
            mgmt_data <= rd_word;
         else if (wr_ok && reg_addr == RA_DATA)
            mgmt_data <= reg_wdata[DATA_W-1:0];
         if (wr_ok && reg_addr == RA_CTRL) begin
            cfg_div   <= reg_wdata[DIV_W-1:0];
            cfg_nopre <= reg_wdata[NOPRE_BIT];
         end
      end
   end

   mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .div      (cfg_div),
      .mdc      (mdc),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   mdio_insync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (mdio_i),
      .q     (mdio_s)
   );

   mdio_frame_seq #(
      .PHY_AW  (PHY_AW),
      .REG_AW  (REG_AW),
      .DATA_W  (DATA_W),
      .PRE_LEN (PRE_LEN)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (cmd_go),
      .start_rd    (cmd_rd),
      .start_nopre (cfg_nopre),
      .phy         (reg_wdata[RD_BIT-1:REG_AW]),
      .regad       (reg_wdata[REG_AW-1:0]),
      .wdata       (mgmt_data),
      .rise_stb    (rise_stb),
      .fall_stb    (fall_stb),
      .mdio_in     (mdio_s),
      .busy        (busy),
      .rd_op       (seq_rd),
      .mdio_o      (mdio_o),
      .mdio_oe     (mdio_oe),
      .rd_done     (rd_done),
      .rd_word     (rd_word)
   );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
   parameter int DIV_W  = 8,
   parameter int DATA_W = 16,
   parameter int HOST_W = 16,
   parameter int RD_BIT = 10,
   parameter int WR_BIT = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [1:0]        reg_addr,
   input logic [HOST_W-1:0] reg_wdata,
   input logic              busy,
   input logic              rd_op,
   input logic              mdc,
   input logic              mdio_o,
   input logic              mdio_oe,
   input logic [DATA_W-1:0] mgmt_data,
   input logic [DIV_W-1:0]  cfg_div,
   input logic              cfg_nopre
);
   logic good_cmd;
   assign good_cmd = reg_wr && (reg_addr == 2'd2) &&
                     (reg_wdata[RD_BIT] ^ reg_wdata[WR_BIT]);

   // R2: an accepted command raises busy on the next clock
   a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (good_cmd && !busy) |=> busy);

   // R8: malformed or absent commands never start a cycle
   a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !good_cmd) |=> !busy);

   // R4: MDC parked low when idle
   a_r4_mdc_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   // R5: output bit moves only with a falling MDC edge
   a_r5_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

   // R6: line released only inside a read, and never while idle
   a_r6_release_read: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mdio_oe) |-> rd_op);
   a_r6_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe);

   // R7: a write drives the line throughout
   a_r7_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rd_op) |-> mdio_oe);

   // R8: host writes during a cycle leave data and control untouched
   a_r8_data_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr && reg_addr == 2'd1) |=> (!busy || $stable(mgmt_data)));
   a_r8_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(cfg_div) && $stable(cfg_nopre)));
endmodule

bind mdio_master mdio_master_chk #(
   .DIV_W  (DIV_W),
   .DATA_W (DATA_W),
   .HOST_W (HOST_W),
   .RD_BIT (REG_AW + PHY_AW),
   .WR_BIT (REG_AW + PHY_AW + 1)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .busy      (busy),
   .rd_op     (seq_rd),
   .mdc       (mdc),
   .mdio_o    (mdio_o),
   .mdio_oe   (mdio_oe),
   .mgmt_data (mgmt_data),
   .cfg_div   (cfg_div),
   .cfg_nopre (cfg_nopre)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd3;
   logic [15:0] reg_wdata = 16'd0;
   logic [7:0]  cfg_div;
   logic        cfg_nopre;
   logic [15:0] mgmt_data;
   logic        busy, mdc, mdio_o, mdio_oe, mdio_i;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   mdio_master uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .cfg_div(cfg_div), .cfg_nopre(cfg_nopre),
      .mgmt_data(mgmt_data), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // ---- PHY responder and wire monitor ----
   int          phy_n = 0;
   int          cap_n = 0;
   logic [63:0] cap = '0;
   logic        m_rd = 1'b0;
   int          m_pre = 32;
   logic [15:0] m_val = '0;
   bit          viol = 1'b0;
   int          cyc = 0;
   int          last_rise = 0;
   int          per_min = 0;
   int          per_max = 0;
   bit          seen_rise = 1'b0;
   logic        drv;

   always @(posedge clk) cyc <= cyc + 1;

   always_comb begin
      int f;
      f = phy_n - m_pre;
      drv = 1'b1;
      if (m_rd) begin
         if (f == 15) drv = 1'b0;
         else if (f >= 16 && f <= 31) drv = m_val[31-f];
      end
   end

   assign mdio_i = mdio_oe ? mdio_o : drv;

   always @(negedge mdc) phy_n = phy_n + 1;

   always @(posedge mdc) begin
      int f;
      f = phy_n - m_pre;
      cap = {cap[62:0], mdio_i};
      cap_n = cap_n + 1;
      if (m_rd && f >= 14 && mdio_oe) viol = 1'b1;
      if (!m_rd && !mdio_oe) viol = 1'b1;
      if (m_rd && f < 14 && !mdio_oe) viol = 1'b1;
      if (seen_rise) begin
         if (cyc - last_rise < per_min) per_min = cyc - last_rise;
         if (cyc - last_rise > per_max) per_max = cyc - last_rise;
      end
      last_rise = cyc;
      seen_rise = 1'b1;
   end

   // ---- helpers ----
   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_frame(input bit rd, input logic [4:0] phy,
                                             input logic [4:0] ra, input logic [15:0] d);
      return {2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, d};
   endfunction

   function automatic int exp_period(input logic [7:0] div);
      int h;
      h = div >> 1;
      if (h == 0) h = 1;
      return 2 * h;
   endfunction

   function automatic logic [15:0] cmd_word(input bit rd, input logic [4:0] phy, input logic [4:0] ra);
      return {4'd0, ~rd, rd, phy, ra};
   endfunction

   task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 2'd3;
   endtask

   task automatic run_txn(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                          input logic [15:0] wd, input logic [15:0] pv,
                          input logic [7:0] div, input bit np,
                          input bit hammer, input bit intrude);
      logic [31:0] ef;
      int tmo;
      wr_reg(2'd0, {7'd0, np, div});
      if (!rd) wr_reg(2'd1, wd);
      m_rd = rd; m_pre = np ? 0 : 32; m_val = pv;
      phy_n = 0; cap = '0; cap_n = 0; viol = 1'b0; seen_rise = 1'b0;
      per_min = 1000000; per_max = 0;
      wr_reg(2'd2, cmd_word(rd, phy, ra));
      check(busy === 1'b1, "R2 busy after command", 64'(busy), 64'd1);
      if (intrude) begin
         wr_reg(2'd2, cmd_word(~rd, ~phy, ~ra));
         wr_reg(2'd1, ~wd);
         wr_reg(2'd0, 16'h0102);
      end
      tmo = 0;
      if (hammer) begin
         reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'hDEAD;
      end
      forever begin
         @(negedge clk);
         if (!busy) break;
         tmo++;
         if (tmo > 20000) break;
      end
      reg_wr = 1'b0; reg_addr = 2'd3;
      check(tmo <= 20000, "R2 busy clears", 64'(tmo), 64'd20000);
      ef = exp_frame(rd, phy, ra, rd ? pv : wd);
      check(cap_n == m_pre + 32, "R3 bit count", 64'(cap_n), 64'(m_pre + 32));
      if (np) check(cap[31:0] == ef, "R3 frame no preamble", 64'(cap[31:0]), 64'(ef));
      else    check(cap == {32'hFFFF_FFFF, ef}, "R3 frame with preamble", cap, {32'hFFFF_FFFF, ef});
      check(!viol, rd ? "R6 line release" : "R7 line drive", 64'(viol), 64'd0);
      check(per_min == exp_period(div) && per_max == exp_period(div), "R4 mdc period",
            64'(per_max), 64'(exp_period(div)));
      check(mgmt_data == (rd ? pv : wd), rd ? "R6 read data" : "R7 data kept",
            64'(mgmt_data), 64'(rd ? pv : wd));
      if (intrude) begin
         check(cfg_div == div && cfg_nopre == np, "R8 control untouched",
               64'({cfg_nopre, cfg_div}), 64'({np, div}));
         repeat (20) @(negedge clk);
         check(busy == 1'b0 && cap_n == m_pre + 32, "R8 no second cycle", 64'(busy), 64'd0);
      end
      @(negedge clk);
   endtask

   // ---- watchdog ----
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // ---- stimulus ----
   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(busy == 1'b0 && mdc == 1'b0 && mdio_oe == 1'b0, "R1 idle outputs",
            64'({busy, mdc, mdio_oe}), 64'd0);
      check(mgmt_data == 16'd0, "R1 data reset", 64'(mgmt_data), 64'd0);
      check(cfg_div == 8'd32 && cfg_nopre == 1'b0, "R1 control reset",
            64'({cfg_nopre, cfg_div}), 64'd32);

      // directed: default divisor, full preamble read
      run_txn(1'b1, 5'h01, 5'h02, 16'h0000, 16'hA5C3, 8'd32, 1'b0, 1'b0, 1'b0);
      // directed: write without preamble
      run_txn(1'b0, 5'h1F, 5'h10, 16'h8001, 16'h0000, 8'd4, 1'b1, 1'b0, 1'b0);
      // directed: divisor below 2 clamps to period 2
      run_txn(1'b0, 5'h0A, 5'h15, 16'h3C3C, 16'h0000, 8'd1, 1'b0, 1'b0, 1'b0);
      // directed: odd divisor rounds down
      run_txn(1'b1, 5'h11, 5'h0E, 16'h0000, 16'hFFFF, 8'd7, 1'b1, 1'b0, 1'b0);
      // R8: intrusions during a write
      run_txn(1'b0, 5'h05, 5'h06, 16'h1234, 16'h0000, 8'd4, 1'b0, 1'b0, 1'b1);
      // R8 and R6: data write on every clock across a read, including the capture edge
      run_txn(1'b1, 5'h07, 5'h08, 16'h0000, 16'h6B2E, 8'd2, 1'b1, 1'b1, 1'b0);

      // R8: malformed commands
      wr_reg(2'd2, 16'h0C21);
      check(busy == 1'b0, "R8 both flags ignored", 64'(busy), 64'd0);
      wr_reg(2'd2, 16'h0321);
      repeat (4) @(negedge clk);
      check(busy == 1'b0 && mdc == 1'b0, "R8 no flag ignored", 64'({busy, mdc}), 64'd0);

      // random mix
      for (int i = 0; i < 20; i++) begin
         logic [7:0] dv;
         dv = 8'($urandom_range(12, 0));
         run_txn(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom),
                 dv, 1'($urandom), 1'b0, (i % 5) == 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule